// File: doc/BRIEF.md
# Range Translation Lookaside Buffer

This block caches a small number of range translations. Each one maps a contiguous run of virtual pages onto a contiguous run of physical pages, and every page in the run has the same protection. An entry holds a lower page bound, an upper page bound, a signed page offset and protection bits. The cache is fully associative, with 32 entries by default.

The first-level TLB probes this block when it misses, in parallel with the second-level page TLB. An entry matches when the probed virtual page lies in its range. On a match the block builds one 4KB page translation for refill into the first-level TLB. That translation carries the probed virtual page, a physical page equal to the virtual page plus the entry's offset, and the entry's protection.

When neither this block nor the second-level TLB hits, the block raises a request to the page-table walker. Software loads entries through a fill port, which replaces entries in round-robin order. An invalidate-all input empties the whole cache.

Top module: `range_tlb`

## Requirements
- R1: After reset every entry is invalid. Every output is 0, and a probe misses.
- R2: A valid entry matches a probed virtual page `v` when `base <= v < limit`, comparing unsigned page numbers. The lower bound is inclusive and the upper bound is exclusive.
- R3: On a hit, `refillPpn` equals the probed page, resized to PPN_W bits, plus the two's-complement `offset`, modulo 2^PPN_W. `refillProt` is the entry's protection, and `refillVpn` is the probed page.
- R4: Every probe is answered exactly one cycle later with `respValid` high. `refillStb` is high exactly when that response is a hit. In cycles with no response, `respValid`, `respHit` and `refillStb` are low.
- R5: `walkReq` is high in a response cycle only when the response is a miss and `l2HitIn` is low in that same cycle.
- R6: When several entries match, the entry with the lowest index supplies the refill, and `multiHit` is high in that response.
- R7: A fill whose limit is not greater than its base is ignored. It writes no entry and does not advance the replacement pointer.
- R8: Accepted fills write entries 0, 1, …, N-1 and then wrap to 0. The (N+1)-th accepted fill after the pointer is cleared evicts the first one.
- R9: `invAll` clears every valid bit and returns the replacement pointer to 0. A fill in the same cycle is dropped.
- R10: A probe in the same cycle as a fill or an invalidate sees the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| probeValid | input | 1 | Probe request after a first-level TLB miss |
| probeVpn | input | VPN_W | Virtual page number to look up |
| l2HitIn | input | 1 | Second-level TLB hit, aligned with the response cycle |
| fillValid | input | 1 | Load a range entry |
| fillBase | input | VPN_W | Lowest virtual page of the range (inclusive) |
| fillLimit | input | VPN_W | Upper virtual page bound (exclusive) |
| fillOffset | input | PPN_W | Two's-complement page offset from virtual to physical |
| fillProt | input | PROT_W | Protection bits of the range |
| invAll | input | 1 | Invalidate every entry |
| respValid | output | 1 | A probe response is present |
| respHit | output | 1 | The response is a range hit |
| refillStb | output | 1 | Refill the first-level TLB with the generated entry |
| refillVpn | output | VPN_W | Virtual page of the generated entry |
| refillPpn | output | PPN_W | Physical page of the generated entry |
| refillProt | output | PROT_W | Protection of the generated entry |
| walkReq | output | 1 | Miss in both the range cache and the second-level TLB |
| multiHit | output | 1 | More than one entry matched this probe |

## Verification
Directed probes at one page below the base, at the base, at the last page before the limit and at the limit itself tell an inclusive bound apart from an exclusive one. A negative offset that wraps around zero exposes a wrong sign extension or a missing modulo in the adder. Overlapping ranges, 33 disjoint fills, rejected empty fills, and a fill or invalidate in the same cycle as a probe separate priority, replacement order, fill rejection and read-before-write timing. Seeded random mixes of overlapping fills, probes, second-level hits and rare invalidations are then compared against a bench model of the entry array.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic wrEn;    // write the entry at wrIdx
    logic clrAll;  // clear every valid bit
    logic lookEn;  // a probe is being looked up
  } ctlStrobe_t;
endpackage

// File: rtl/range_tlb_ctl.sv
module range_tlb_ctl
  import range_tlb_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int ENTRIES = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             probeValid,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillBase,
  input  logic [VPN_W-1:0] fillLimit,
  input  logic             invAll,
  output ctlStrobe_t       strobes,
  output logic [IDX_W-1:0] wrIdx
);
  logic [IDX_W-1:0] rrPtr;
  logic             fillOk;

  // empty or inverted ranges are dropped; invalidate wins over a fill
  assign fillOk = fillValid && (fillLimit > fillBase) && !invAll;

  always_comb begin
    strobes.wrEn   = fillOk;
    strobes.clrAll = invAll;
    strobes.lookEn = probeValid;
    wrIdx          = rrPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN || invAll) begin
      rrPtr <= '0;
    end else if (fillOk) begin
      if (rrPtr == IDX_W'(ENTRIES - 1)) rrPtr <= '0;
      else                              rrPtr <= rrPtr + 1'b1;
    end
  end
endmodule

// File: rtl/range_tlb_dp.sv
module range_tlb_dp
  import range_tlb_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PROT_W  = 3,
  parameter int ENTRIES = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int EXT_W  = (VPN_W > PPN_W) ? VPN_W : PPN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobes,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [VPN_W-1:0]  probeVpn,
  input  logic              l2HitIn,
  input  logic [VPN_W-1:0]  fillBase,
  input  logic [VPN_W-1:0]  fillLimit,
  input  logic [PPN_W-1:0]  fillOffset,
  input  logic [PROT_W-1:0] fillProt,
  output logic              respValid,
  output logic              respHit,
  output logic              refillStb,
  output logic [VPN_W-1:0]  refillVpn,
  output logic [PPN_W-1:0]  refillPpn,
  output logic [PROT_W-1:0] refillProt,
  output logic              walkReq,
  output logic              multiHit
);
  logic [VPN_W-1:0]  baseQ  [ENTRIES];
  logic [VPN_W-1:0]  limitQ [ENTRIES];
  logic [PPN_W-1:0]  offQ   [ENTRIES];
  logic [PROT_W-1:0] protQ  [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] matchVec;

  // bound comparators, one pair per entry
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign matchVec[e] = validQ[e] && (probeVpn >= baseQ[e]) && (probeVpn < limitQ[e]);
  end

  // lowest index wins
  logic [PPN_W-1:0]  selOff;
  logic [PROT_W-1:0] selProt;
  logic              anyHit;
  always_comb begin
    selOff  = '0;
    selProt = '0;
    anyHit  = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (matchVec[e] && !anyHit) begin
        anyHit  = 1'b1;
        selOff  = offQ[e];
        selProt = protQ[e];
      end
    end
  end

  logic [EXT_W-1:0] vpnExt;
  logic [PPN_W-1:0] genPpn;
  logic             manyHit;
  assign vpnExt  = EXT_W'(probeVpn);
  assign genPpn  = vpnExt[PPN_W-1:0] + selOff;
  assign manyHit = $countones(matchVec) > 1;

  // entry storage
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clrAll) begin
      validQ <= '0;
    end else if (strobes.wrEn) begin
      validQ[wrIdx] <= 1'b1;
    end
    if (strobes.wrEn) begin
      baseQ[wrIdx]  <= fillBase;
      limitQ[wrIdx] <= fillLimit;
      offQ[wrIdx]   <= fillOffset;
      protQ[wrIdx]  <= fillProt;
    end
  end

  // response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respHit    <= 1'b0;
      multiHit   <= 1'b0;
      refillVpn  <= '0;
      refillPpn  <= '0;
      refillProt <= '0;
    end else begin
      respValid  <= strobes.lookEn;
      respHit    <= strobes.lookEn && anyHit;
      multiHit   <= strobes.lookEn && manyHit;
      if (strobes.lookEn && anyHit) begin
        refillVpn  <= probeVpn;
        refillPpn  <= genPpn;
        refillProt <= selProt;
      end
    end
  end

  assign refillStb = respValid && respHit;
  assign walkReq   = respValid && !respHit && !l2HitIn;
endmodule

// File: rtl/range_tlb.sv
module range_tlb
  import range_tlb_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PROT_W  = 3,
  parameter int ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              probeValid,
  input  logic [VPN_W-1:0]  probeVpn,
  input  logic              l2HitIn,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillBase,
  input  logic [VPN_W-1:0]  fillLimit,
  input  logic [PPN_W-1:0]  fillOffset,
  input  logic [PROT_W-1:0] fillProt,
  input  logic              invAll,
  output logic              respValid,
  output logic              respHit,
  output logic              refillStb,
  output logic [VPN_W-1:0]  refillVpn,
  output logic [PPN_W-1:0]  refillPpn,
  output logic [PROT_W-1:0] refillProt,
  output logic              walkReq,
  output logic              multiHit
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  ctlStrobe_t       strobes;
  logic [IDX_W-1:0] wrIdx;

  range_tlb_ctl #(.VPN_W(VPN_W), .ENTRIES(ENTRIES)) ctl_i (
    .clk(clk), .rstN(rstN), .probeValid(probeValid), .fillValid(fillValid),
    .fillBase(fillBase), .fillLimit(fillLimit), .invAll(invAll),
    .strobes(strobes), .wrIdx(wrIdx)
  );

  range_tlb_dp #(.VPN_W(VPN_W), .PPN_W(PPN_W), .PROT_W(PROT_W), .ENTRIES(ENTRIES)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrIdx(wrIdx),
    .probeVpn(probeVpn), .l2HitIn(l2HitIn), .fillBase(fillBase),
    .fillLimit(fillLimit), .fillOffset(fillOffset), .fillProt(fillProt),
    .respValid(respValid), .respHit(respHit), .refillStb(refillStb),
    .refillVpn(refillVpn), .refillPpn(refillPpn), .refillProt(refillProt),
    .walkReq(walkReq), .multiHit(multiHit)
  );
endmodule

// File: rtl/range_tlb_chk.sv
module range_tlb_chk #(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int PROT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             probeValid,
  input logic [VPN_W-1:0] probeVpn,
  input logic             invAll,
  input logic             respValid,
  input logic             respHit,
  input logic             refillStb,
  input logic [VPN_W-1:0] refillVpn,
  input logic             walkReq,
  input logic             multiHit
);
  // R4: a probe is answered in the next cycle
  a_r4_probe_answered: assert property (@(posedge clk) disable iff (!rstN)
    probeValid |=> respValid);
  a_r4_no_spurious_resp: assert property (@(posedge clk) disable iff (!rstN)
    !probeValid |=> !respValid && !refillStb);
  a_r4_refill_is_hit: assert property (@(posedge clk) disable iff (!rstN)
    refillStb |-> respValid && respHit);
  // R3: the generated entry carries the probed page
  a_r3_refill_vpn: assert property (@(posedge clk) disable iff (!rstN)
    refillStb |-> refillVpn == $past(probeVpn));
  // R5: walk only on a range miss
  a_r5_walk_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    walkReq |-> respValid && !respHit);
  // R6: several matches imply a hit
  a_r6_multi_implies_hit: assert property (@(posedge clk) disable iff (!rstN)
    multiHit |-> respHit);
  // R9: a probe right after invalidate-all misses
  a_r9_empty_after_inv: assert property (@(posedge clk) disable iff (!rstN)
    invAll ##1 probeValid |=> !respHit);
endmodule

bind range_tlb range_tlb_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W), .PROT_W(PROT_W)) chk_i (
  .clk(clk), .rstN(rstN), .probeValid(probeValid), .probeVpn(probeVpn),
  .invAll(invAll), .respValid(respValid), .respHit(respHit),
  .refillStb(refillStb), .refillVpn(refillVpn), .walkReq(walkReq),
  .multiHit(multiHit)
);

// File: tb/range_tlb_tb.sv
`timescale 1ns/1ps
module range_tlb_tb_top;
  localparam int VW = 20, PW = 20, RW = 3, N = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic probeValid = 0, l2HitIn = 0, fillValid = 0, invAll = 0;
  logic [VW-1:0] probeVpn = '0, fillBase = '0, fillLimit = '0;
  logic [PW-1:0] fillOffset = '0;
  logic [RW-1:0] fillProt = '0;
  logic respValid, respHit, refillStb, walkReq, multiHit;
  logic [VW-1:0] refillVpn;
  logic [PW-1:0] refillPpn;
  logic [RW-1:0] refillProt;

  always #2 clk = ~clk;

  range_tlb #(.VPN_W(VW), .PPN_W(PW), .PROT_W(RW), .ENTRIES(N)) dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the entry array
  logic [VW-1:0] mB [N];
  logic [VW-1:0] mL [N];
  logic [PW-1:0] mO [N];
  logic [RW-1:0] mP [N];
  bit            mV [N];
  int            mPtr = 0;

  // expected {respValid,respHit,refillStb,multiHit,walkReq,vpn,ppn,prot}
  function automatic logic [4+VW+PW+RW:0] expect_resp(bit pv, logic [VW-1:0] v, bit l2);
    bit hit = 0; int cnt = 0; logic [PW-1:0] ppn = '0; logic [RW-1:0] pr = '0;
    for (int e = 0; e < N; e++)
      if (mV[e] && v >= mB[e] && v < mL[e]) begin
        cnt++;
        if (!hit) begin hit = 1; ppn = PW'(v) + mO[e]; pr = mP[e]; end
      end
    if (!pv) return '0;
    return {1'b1, hit, hit, cnt > 1, !hit && !l2, hit ? v : VW'(0), ppn, pr};
  endfunction

  function automatic void model_update(bit fv, logic [VW-1:0] b, logic [VW-1:0] l,
                                        logic [PW-1:0] o, logic [RW-1:0] p, bit inv);
    if (inv) begin
      for (int e = 0; e < N; e++) mV[e] = 0;
      mPtr = 0;
    end else if (fv && l > b) begin
      mB[mPtr] = b; mL[mPtr] = l; mO[mPtr] = o; mP[mPtr] = p; mV[mPtr] = 1;
      mPtr = (mPtr + 1) % N;
    end
  endfunction

  // one cycle: drive at negedge, check the response at the following negedge
  task automatic step(string tag, bit pv, logic [VW-1:0] v, bit l2,
                      bit fv, logic [VW-1:0] b, logic [VW-1:0] l,
                      logic [PW-1:0] o, logic [RW-1:0] p, bit inv);
    logic [4+VW+PW+RW:0] exp, act;
    exp = expect_resp(pv, v, l2);
    probeValid = pv; probeVpn = v; l2HitIn = l2;
    fillValid = fv; fillBase = b; fillLimit = l; fillOffset = o; fillProt = p; invAll = inv;
    @(posedge clk);
    model_update(fv, b, l, o, p, inv);
    @(negedge clk);
    probeValid = 0; fillValid = 0; invAll = 0;
    act = {respValid, respHit, refillStb, multiHit, walkReq,
           respHit ? refillVpn : VW'(0), respHit ? refillPpn : PW'(0),
           respHit ? refillProt : RW'(0)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s vpn=%h actual=%h expected=%h", tag, v, act, exp);
    end
  endtask

  task automatic probe(string tag, logic [VW-1:0] v, bit l2);
    step(tag, 1, v, l2, 0, '0, '0, '0, '0, 0);
  endtask
  task automatic fill(string tag, logic [VW-1:0] b, logic [VW-1:0] l,
                      logic [PW-1:0] o, logic [RW-1:0] p);
    step(tag, 0, '0, 0, 1, b, l, o, p, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int e = 0; e < N; e++) mV[e] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    checks++;
    if ({respValid, respHit, refillStb, walkReq, multiHit} !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%b expected=00000",
               {respValid, respHit, refillStb, walkReq, multiHit});
    end
    probe("R1 empty miss", 20'h0, 0);
    probe("R1 empty miss l2", 20'h123, 1);

    // R2 bounds, R3 offset and protection
    fill("R2 fill", 20'd100, 20'd200, 20'd1000, 3'd5);
    probe("R2 below base", 20'd99, 0);
    probe("R2 at base", 20'd100, 0);
    probe("R2 last page", 20'd199, 1);
    probe("R2 at limit", 20'd200, 1);
    // R3 negative offset wraps modulo 2^PPN_W
    fill("R3 fill", 20'h1000, 20'h1010, -20'sh2000, 3'd2);
    probe("R3 wrap", 20'h1005, 0);
    // R6 overlap: entry 2 covers [150,300)
    fill("R6 fill", 20'd150, 20'd300, 20'd7, 3'd1);
    probe("R6 lowest index", 20'd180, 0);
    probe("R6 single", 20'd250, 0);
    // R7 rejected fills
    fill("R7 empty", 20'd500, 20'd500, 20'd1, 3'd7);
    fill("R7 inverted", 20'd600, 20'd550, 20'd1, 3'd7);
    probe("R7 no entry", 20'd500, 0);
    probe("R7 no entry", 20'd560, 0);
    // R10 probe during fill sees old contents
    step("R10 probe with fill", 1, 20'd800, 0, 1, 20'd800, 20'd900, 20'd3, 3'd4, 0);
    probe("R10 visible next", 20'd850, 0);
    // R9 invalidate beats fill; probe in that cycle sees old contents
    step("R9 R10 probe with inv", 1, 20'd150, 0, 1, 20'd2000, 20'd2100, 20'd9, 3'd3, 1);
    probe("R9 cleared", 20'd150, 0);
    probe("R9 fill dropped", 20'd2050, 1);
    // R8 round-robin wrap
    for (int i = 0; i < N; i++)
      fill("R8 fill", 20'(i * 64), 20'(i * 64 + 64), 20'(i), 3'(i));
    fill("R8 evict", 20'd5000, 20'd5100, 20'd11, 3'd6);
    probe("R8 evicted", 20'd10, 0);
    probe("R8 kept", 20'd70, 0);
    probe("R8 new", 20'd5050, 0);
    probe("R5 walk", 20'd9999, 0);
    probe("R5 l2 covers", 20'd9999, 1);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom % 100;
      logic [VW-1:0] b = VW'($urandom % 4096);
      logic [VW-1:0] l = (r % 7 == 0) ? b - VW'($urandom % 3) : b + VW'(1 + $urandom % 512);
      step("R2 R3 R4 R5 R6 R7 R8 random", r < 70, VW'($urandom % 4700), $urandom % 2,
           (r >= 40 && r < 98), b, l, PW'($urandom), RW'($urandom), r >= 98);
    end
    repeat (2) begin
      step("R4 idle", 0, '0, 0, 0, '0, '0, '0, '0, 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule